// File: doc/BRIEF.md
# DAC Test Source Selector

This block chooses what feeds three 10-bit DAC code outputs. In normal operation the three processed video channels pass through. For test work the outputs can come from a fixed code per channel held in configuration inputs, from an internal sawtooth that is either fast or slow, or from the raw input bus with no processing in between. The slow sawtooth holds each code long enough to measure static linearity. The raw-input path runs at full clock rate.

When the processed video is in a luma/chroma format, the luma channel (output 0) can be held back by 0 to 7 extra clocks relative to the two chroma channels. This lines up the luma path with chroma paths that take longer. All three outputs are registered, so each source reaches the pins one clock after it is presented. The only exception is the extra luma delay.

Top module: `dac_src_sel`

## Requirements
- R1: While `reg_en` is 1, after the next clock edge `dac0`, `dac1` and `dac2` equal `reg_code0`, `reg_code1` and `reg_code2`. Ramp, bypass, video and luma delay inputs have no effect.
- R2: While `ramp_fast` selects the ramp, all three outputs carry the same code. That code rises by one on every clock and wraps from 1023 to 0.
- R3: While `ramp_slow` alone selects the ramp, all three outputs carry the same code. That code rises by one every 1024 clocks and wraps from 1023 to 0.
- R4: At the first edge on which a ramp kind (fast or slow) becomes the source, or replaces the other kind, the outputs load code 0. The count then proceeds from 0.
- R5: With bypass selected, `dac0` takes `raw_bus[9:0]`, `dac1` takes `raw_bus[19:10]` and `dac2` takes `raw_bus[29:20]`, one clock later. No luma delay is applied.
- R6: With normal video selected and `ycbcr_mode` at 0, `dac0`, `dac1` and `dac2` take `vid_y`, `vid_cb` and `vid_cr` one clock later.
- R7: With normal video selected and `ycbcr_mode` at 1, `dac0` shows the `vid_y` value presented `luma_dly` clocks before the one that `dac1`/`dac2` show. A `luma_dly` of 0 adds no latency. With `ycbcr_mode` at 0, `luma_dly` has no effect.
- R8: Priority, highest first, is: register codes, fast ramp, slow ramp, bypass, normal video.
- R9: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_y | input | 10 | Processed luma (or green) channel |
| vid_cb | input | 10 | Processed Cb (or blue) channel |
| vid_cr | input | 10 | Processed Cr (or red) channel |
| raw_bus | input | 30 | Unprocessed input bus, three 10-bit lanes |
| reg_en | input | 1 | Select fixed register codes |
| reg_code0 | input | 10 | Fixed code for output 0 |
| reg_code1 | input | 10 | Fixed code for output 1 |
| reg_code2 | input | 10 | Fixed code for output 2 |
| ramp_fast | input | 1 | Select the fast ramp |
| ramp_slow | input | 1 | Select the slow ramp |
| bypass_en | input | 1 | Select the raw input bus |
| ycbcr_mode | input | 1 | Video is luma/chroma; enables the luma delay |
| luma_dly | input | 3 | Extra luma delay in clocks, 0 to 7 |
| dac0 | output | 10 | DAC code, channel 0 (luma) |
| dac1 | output | 10 | DAC code, channel 1 |
| dac2 | output | 10 | DAC code, channel 2 |

## Verification
Every result is due at the first clock edge after the inputs that produce it are set up. The one exception is the delayed luma, which carries the `vid_y` value from `luma_dly` edges earlier. The driver records which edge each expected triple belongs to, and keeps a history of `vid_y` per edge for the delayed luma. The monitor compares only in the half-period after that edge, never at the edge. Ramp values come from a step-by-step model of the count and its prescaler, so the 1024-clock hold and the 1023-to-0 wrap are each checked on the exact edge where they happen.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;

    // Output source, ordered so that a larger value wins
    typedef enum logic [2:0] {
        SRC_VIDEO  = 3'd0,
        SRC_BYPASS = 3'd1,
        SRC_SLOW   = 3'd2,
        SRC_FAST   = 3'd3,
        SRC_REG    = 3'd4
    } src_e;

    function automatic src_e pick_src(
        input logic reg_en,
        input logic fast,
        input logic slow,
        input logic byp
    );
        if (reg_en)    return SRC_REG;
        else if (fast) return SRC_FAST;
        else if (slow) return SRC_SLOW;
        else if (byp)  return SRC_BYPASS;
        else           return SRC_VIDEO;
    endfunction

endpackage

// File: rtl/dac_ramp_gen.sv
module dac_ramp_gen
    import dac_src_pkg::*;
#(
    parameter int W         = 10,
    parameter int SLOW_LOG2 = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  src_e         src_i,
    output logic [W-1:0] ramp_o
);

    localparam logic [SLOW_LOG2-1:0] PRE_MAX = '1;

    typedef struct packed {
        logic [W-1:0]         cnt;
        logic [SLOW_LOG2-1:0] pre;
        src_e                 kind;
    } ramp_st_t;

    ramp_st_t             st_q, st_d;
    logic                 restart;
    logic [W-1:0]         cur_v;
    logic [SLOW_LOG2-1:0] cur_p;

    always_comb begin
        // a change of source restarts the sawtooth from code 0
        restart = (src_i != st_q.kind);
        cur_v   = restart ? '0 : st_q.cnt;
        cur_p   = restart ? '0 : st_q.pre;
        st_d      = st_q;
        st_d.kind = src_i;
        st_d.cnt  = cur_v;
        st_d.pre  = cur_p;
        unique case (src_i)
            SRC_FAST: begin
                st_d.cnt = cur_v + W'(1);
                st_d.pre = '0;
            end
            SRC_SLOW: begin
                if (cur_p == PRE_MAX) begin
                    st_d.cnt = cur_v + W'(1);
                    st_d.pre = '0;
                end else begin
                    st_d.pre = cur_p + SLOW_LOG2'(1);
                end
            end
            default: begin
                st_d.cnt = '0;
                st_d.pre = '0;
            end
        endcase
        ramp_o = cur_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, pre: '0, kind: SRC_VIDEO};
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the slow count stays put until the prescaler completes
    a_r3_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == SRC_SLOW && st_q.kind == SRC_SLOW && st_q.pre != PRE_MAX)
        |=> (st_q.cnt == $past(st_q.cnt)));

    // R3: the slow count advances by one when the prescaler wraps
    a_r3_slow_step: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == SRC_SLOW && st_q.kind == SRC_SLOW && st_q.pre == PRE_MAX)
        |=> (st_q.cnt == $past(st_q.cnt) + W'(1)));

endmodule

// File: rtl/dac_luma_skew.sv
module dac_luma_skew #(
    parameter int W       = 10,
    parameter int DLY_MAX = 7,
    parameter int DLY_W   = $clog2(DLY_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     y_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic [W-1:0]     y_o
);

    logic [W-1:0] stg_q [DLY_MAX];
    logic [W-1:0] stg_d [DLY_MAX];

    always_comb begin
        stg_d[0] = y_i;
        for (int i = 1; i < DLY_MAX; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        // tap 0 is the undelayed input; tap k is stage k-1
        if (dly_i == '0) begin
            y_o = y_i;
        end else if (int'(dly_i) > DLY_MAX) begin
            y_o = stg_q[DLY_MAX-1];
        end else begin
            y_o = stg_q[int'(dly_i) - 1];
        end
    end

    generate
        for (genvar g = 0; g < DLY_MAX; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= '0;
                end else begin
                    stg_q[g] <= stg_d[g];
                end
            end
        end
    endgenerate

    // R7: the first stage holds the luma input of the previous clock
    a_r7_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stg_q[0] == $past(y_i)));

endmodule

// File: rtl/dac_src_sel.sv
module dac_src_sel
    import dac_src_pkg::*;
#(
    parameter int W         = 10,
    parameter int DLY_MAX   = 7,
    parameter int DLY_W     = $clog2(DLY_MAX + 1),
    parameter int SLOW_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     vid_y,
    input  logic [W-1:0]     vid_cb,
    input  logic [W-1:0]     vid_cr,
    input  logic [3*W-1:0]   raw_bus,
    input  logic             reg_en,
    input  logic [W-1:0]     reg_code0,
    input  logic [W-1:0]     reg_code1,
    input  logic [W-1:0]     reg_code2,
    input  logic             ramp_fast,
    input  logic             ramp_slow,
    input  logic             bypass_en,
    input  logic             ycbcr_mode,
    input  logic [DLY_W-1:0] luma_dly,
    output logic [W-1:0]     dac0,
    output logic [W-1:0]     dac1,
    output logic [W-1:0]     dac2
);

    typedef struct packed {
        logic [W-1:0] c0;
        logic [W-1:0] c1;
        logic [W-1:0] c2;
    } dac_out_t;

    src_e         src;
    logic [W-1:0] ramp_val;
    logic [W-1:0] y_late;
    logic [W-1:0] y_sel;
    dac_out_t     out_q, out_d;

    dac_ramp_gen #(.W(W), .SLOW_LOG2(SLOW_LOG2)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src),
        .ramp_o (ramp_val)
    );

    dac_luma_skew #(.W(W), .DLY_MAX(DLY_MAX), .DLY_W(DLY_W)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .y_i   (vid_y),
        .dly_i (luma_dly),
        .y_o   (y_late)
    );

    always_comb begin
        src   = pick_src(reg_en, ramp_fast, ramp_slow, bypass_en);
        y_sel = ycbcr_mode ? y_late : vid_y;
        unique case (src)
            SRC_REG:            out_d = '{c0: reg_code0, c1: reg_code1, c2: reg_code2};
            SRC_FAST, SRC_SLOW: out_d = '{c0: ramp_val, c1: ramp_val, c2: ramp_val};
            SRC_BYPASS:         out_d = '{c0: raw_bus[W-1:0],
                                          c1: raw_bus[2*W-1:W],
                                          c2: raw_bus[3*W-1:2*W]};
            default:            out_d = '{c0: y_sel, c1: vid_cb, c2: vid_cr};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dac0 = out_q.c0;
    assign dac1 = out_q.c1;
    assign dac2 = out_q.c2;

    // R1: register codes reach the pins one clock later
    a_r1_static: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |=> (dac0 == $past(reg_code0) && dac1 == $past(reg_code1)
                    && dac2 == $past(reg_code2)));

    // R2: consecutive fast-ramp clocks step the code by one
    a_r2_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_FAST && $past(src) == SRC_FAST)
        |=> (dac0 == $past(dac0) + W'(1) && dac1 == dac0 && dac2 == dac0));

    // R4: a newly chosen ramp kind starts at code 0
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == SRC_FAST || src == SRC_SLOW) && src != $past(src))
        |=> (dac0 == '0 && dac1 == '0 && dac2 == '0));

    // R5 and R8: bypass lanes pass unchanged when nothing outranks them
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_en && !ramp_fast && !ramp_slow && bypass_en)
        |=> ({dac2, dac1, dac0} == $past(raw_bus)));

    // R6: chroma channels carry processed video one clock later
    a_r6_chroma: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_VIDEO) |=> (dac1 == $past(vid_cb) && dac2 == $past(vid_cr)));

    // R9: outputs are cleared by reset
    a_r9_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (dac0 == '0 && dac1 == '0 && dac2 == '0));

endmodule

// File: tb/sim_dac_src_sel.sv
`timescale 1ns/1ps
module sim_dac_src_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  vid_y = '0, vid_cb = '0, vid_cr = '0;
    logic [29:0] raw_bus = '0;
    logic        reg_en = 1'b0;
    logic [9:0]  reg_code0 = '0, reg_code1 = '0, reg_code2 = '0;
    logic        ramp_fast = 1'b0, ramp_slow = 1'b0, bypass_en = 1'b0;
    logic        ycbcr_mode = 1'b0;
    logic [2:0]  luma_dly = '0;
    logic [9:0]  dac0, dac1, dac2;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int          q_due[$];
    logic [29:0] q_exp[$];
    string       q_tag[$];
    logic [9:0]  y_hist[int];

    int         m_kind = 0;
    logic [9:0] m_cnt  = '0;
    int         m_pre  = 0;

    always #10 clk = ~clk;

    dac_src_sel u0 (
        .clk(clk), .rst_n(rst_n),
        .vid_y(vid_y), .vid_cb(vid_cb), .vid_cr(vid_cr),
        .raw_bus(raw_bus), .reg_en(reg_en),
        .reg_code0(reg_code0), .reg_code1(reg_code1), .reg_code2(reg_code2),
        .ramp_fast(ramp_fast), .ramp_slow(ramp_slow), .bypass_en(bypass_en),
        .ycbcr_mode(ycbcr_mode), .luma_dly(luma_dly),
        .dac0(dac0), .dac1(dac1), .dac2(dac2)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each expected triple in the half-cycle after its edge
    always @(negedge clk) begin
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            logic [29:0] exp_v;
            string       tg;
            exp_v = q_exp.pop_front();
            tg    = q_tag.pop_front();
            void'(q_due.pop_front());
            n_checks++;
            if ({dac2, dac1, dac0} !== exp_v) begin
                n_errors++;
                $display("FAIL %s cycle %0d: got %0d/%0d/%0d expected %0d/%0d/%0d",
                         tg, cyc, dac0, dac1, dac2,
                         exp_v[9:0], exp_v[19:10], exp_v[29:20]);
            end
        end
    end

    function automatic logic [9:0] hist_at(int idx);
        if (y_hist.exists(idx)) return y_hist[idx];
        return '0;
    endfunction

    // driver: model the edge that the current inputs will meet, then advance
    task automatic tick(input string tg);
        int         n;
        int         kind;
        logic [9:0] v, e0, e1, e2;
        int         p;
        n = cyc + 1;
        y_hist[n] = vid_y;
        kind = reg_en ? 0 : (ramp_fast ? 2 : (ramp_slow ? 1 : 0));
        if (kind != m_kind) begin v = '0; p = 0; end
        else begin v = m_cnt; p = m_pre; end
        if (kind == 2) begin m_cnt = v + 10'd1; m_pre = 0; end
        else if (kind == 1) begin
            if (p == 1023) begin m_cnt = v + 10'd1; m_pre = 0; end
            else begin m_cnt = v; m_pre = p + 1; end
        end else begin m_cnt = '0; m_pre = 0; end
        m_kind = kind;
        if (reg_en) begin e0 = reg_code0; e1 = reg_code1; e2 = reg_code2; end
        else if (kind != 0) begin e0 = v; e1 = v; e2 = v; end
        else if (bypass_en) begin e0 = raw_bus[9:0]; e1 = raw_bus[19:10]; e2 = raw_bus[29:20]; end
        else begin
            e0 = ycbcr_mode ? hist_at(n - int'(luma_dly)) : vid_y;
            e1 = vid_cb;
            e2 = vid_cr;
        end
        q_due.push_back(n);
        q_exp.push_back({e2, e1, e0});
        q_tag.push_back(tg);
        @(negedge clk);
    endtask

    task automatic rand_video();
        vid_y   = 10'($urandom);
        vid_cb  = 10'($urandom);
        vid_cr  = 10'($urandom);
        raw_bus = 30'($urandom);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired: got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs cleared while reset is held
        n_checks++;
        if ({dac0, dac1, dac2} !== 30'd0) begin
            n_errors++;
            $display("FAIL R9 reset: got %0d/%0d/%0d expected 0/0/0", dac0, dac1, dac2);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R6: plain pass-through, luma delay setting ignored without ycbcr_mode
        luma_dly = 3'd5;
        for (int i = 0; i < 20; i++) begin rand_video(); tick("R6"); end

        // R7: each luma delay from 0 to 7
        ycbcr_mode = 1'b1;
        for (int d = 0; d < 8; d++) begin
            luma_dly = 3'(d);
            for (int i = 0; i < 12; i++) begin rand_video(); tick("R7"); end
        end
        ycbcr_mode = 1'b0;
        for (int i = 0; i < 6; i++) begin rand_video(); tick("R7 ignored"); end

        // R5: bypass, luma delay not applied even with ycbcr_mode
        ycbcr_mode = 1'b1; luma_dly = 3'd3; bypass_en = 1'b1;
        for (int i = 0; i < 20; i++) begin rand_video(); tick("R5"); end

        // R1 and R8: register codes outrank everything else
        reg_en = 1'b1; ramp_fast = 1'b1; ramp_slow = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rand_video();
            reg_code0 = 10'($urandom); reg_code1 = 10'($urandom); reg_code2 = 10'($urandom);
            tick("R1/R8");
        end
        reg_code0 = 10'd1023; reg_code1 = 10'd0; reg_code2 = 10'd512;
        tick("R1 extremes");

        // R2, R4, R8: fast ramp starts at 0, steps each clock, wraps at 1023
        reg_en = 1'b0;
        for (int i = 0; i < 1030; i++) begin rand_video(); tick("R2/R4/R8"); end

        // R4: switching to slow restarts at 0; R3: slow step every 1024 clocks
        ramp_fast = 1'b0;
        for (int i = 0; i < 2060; i++) begin rand_video(); tick("R3/R4"); end

        // R4: back to fast restarts again; R8: bypass under a ramp has no effect
        ramp_fast = 1'b1;
        for (int i = 0; i < 8; i++) begin rand_video(); tick("R4 fast again"); end

        // R6: back to video after all test modes
        ramp_fast = 1'b0; ramp_slow = 1'b0; bypass_en = 1'b0; ycbcr_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin rand_video(); tick("R6 return"); end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule